// File: doc/BRIEF.md
# Banked PCS Management Register Window

This block is the slave-side register file behind a 16-bit management window of a serial-link PCS. Software reaches it through an 8 KiB window. A base selector at a fixed word in that window chooses which of four register banks the remaining words reach: standard control, standard MII, time-sync or vendor MII. The base selector stays reachable whichever bank is selected. Register contents are plain storage. Each register comes out of reset with a fixed default value, and no PCS datapath, autonegotiation or SerDes behaviour feeds back into any register.

Software addresses the window by 16-bit word. Word `w` corresponds to byte offset `2*w`, and the same number `w` is the register index inside the selected bank. Reads are combinational. Writes commit on the rising clock edge. Setting bit 15 of the MII control register starts a soft reset. The soft reset reloads the defaults of all four banks and leaves the base selector as it was.

Top module: `pcs_regwin`

## Requirements
- R1: After hardware reset, the base selector reads 0x0000 and every bank register holds its default value. The non-zero defaults are listed by word index, and every other register is 0.
  - Control bank: index 4 = 0x699E, index 8 = 0x8000.
  - MII bank: 0 = 0x1140, 1 = 0x0109, 2 = 0x699E, 3 = 0xCED0, 4 = 0x0020, 15 = 0xC000.
  - Time-sync bank: 8 = 0x0003, 9 = 0x0038, 11 = 0x0038, 13 = 0x0058, 15 = 0x0048.
  - Vendor bank: 0x00 = 0x2400, 0x02 = 0x000A, 0x06 = 0x899C, 0x10 = 0x0010, 0x38 = 0x000A, 0x3A = 0x007F, 0x3D = 0x0001, 0x58 = 0x0100, 0x59 = 0x1100, 0x5D = 0x000E, 0x78 = 0x0100, 0x79 = 0x0032, 0x88 = 0x0001, 0x98 = 0x0019.
- R2: Word address 0xFF (byte offset 0x1FE) always reads and writes the 16-bit base selector, whatever bank is selected.
- R3: These base values select a bank: 0x1E00 selects control, 0x1F00 selects MII, 0x1F07 selects time-sync and 0x1F80 selects vendor.
- R4: A write to word `w` of the selected bank stores the data in register `w` of that bank. The value reads back from the next cycle onward, and no other bank changes.
- R5: While the base selector holds any value not listed in R3, every read outside word 0xFF returns 0 and every write outside word 0xFF is dropped.
- R6: The banks hold 9 (control), 16 (MII), 17 (time-sync) and 227 (vendor) registers. A read at a word index at or beyond the bank's size returns 0, and a write there is dropped.
- R7: A write to MII bank word 0 with bit 15 set reloads every bank with its R1 defaults on that same edge. The written value is discarded, so bit 15 reads back clear.
- R8: A soft reset leaves the base selector unchanged. Only hardware reset clears it.
- R9: A write to MII bank word 0 with bit 15 clear is stored like any other register.
- R10: Read data follows the address and the base selector in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Write strobe for the current word |
| bus_waddr | input | 12 | Word address within the 8 KiB window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |

## Verification
The bench drives a long seeded random mix of base-selector writes, in-range and out-of-range bank accesses and MII control writes against a bench-side model of all four banks. It also scans every bank completely after the directed cases.

The corner cases it targets, with the symptom of each fault:
- Index equal to the bank size: a wrong range check aliases a register or lets a write through.
- Unknown base values, including one that differs from a valid code in a single bit: a loose compare reaches a bank.
- Soft reset followed by a read of the base selector: a design that resets the selector reads 0 there.
- Soft reset on a bank other than MII: a soft reset that misses a bank leaves old data in it.
- MII control write without bit 15: a design that triggers on the wrong bit reloads the banks here.

// File: rtl/pcs_regwin_pkg.sv
package pcs_regwin_pkg;

    localparam int DATA_W     = 16;
    localparam int WADDR_W    = 12;                 // 8 KiB window, 16-bit words
    localparam logic [WADDR_W-1:0] BASE_WADDR = 12'h0FF;
    localparam int SRST_BIT   = 15;

    localparam int CTL_BYTES_D = 'h12;
    localparam int MII_BYTES_D = 'h20;
    localparam int TSY_BYTES_D = 'h22;
    localparam int VND_BYTES_D = 'h1C6;

    typedef enum logic [1:0] {
        BK_CTL = 2'd0,
        BK_MII = 2'd1,
        BK_TSY = 2'd2,
        BK_VND = 2'd3
    } bank_e;

    localparam int NUM_BANKS = 4;

    localparam logic [DATA_W-1:0] CODE_CTL = 16'h1E00;
    localparam logic [DATA_W-1:0] CODE_MII = 16'h1F00;
    localparam logic [DATA_W-1:0] CODE_TSY = 16'h1F07;
    localparam logic [DATA_W-1:0] CODE_VND = 16'h1F80;

    typedef struct packed {
        logic               wr;
        logic [WADDR_W-1:0] waddr;
        logic [DATA_W-1:0]  wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] bank_code(bank_e b);
        case (b)
            BK_CTL:  return CODE_CTL;
            BK_MII:  return CODE_MII;
            BK_TSY:  return CODE_TSY;
            default: return CODE_VND;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_default(bank_e b, int unsigned idx);
        logic [DATA_W-1:0] v;
        v = '0;
        case (b)
            BK_CTL: case (idx)
                4: v = 16'h699E;
                8: v = 16'h8000;
                default: v = '0;
            endcase
            BK_MII: case (idx)
                0:  v = 16'h1140;
                1:  v = 16'h0109;
                2:  v = 16'h699E;
                3:  v = 16'hCED0;
                4:  v = 16'h0020;
                15: v = 16'hC000;
                default: v = '0;
            endcase
            BK_TSY: case (idx)
                8:  v = 16'h0003;
                9:  v = 16'h0038;
                11: v = 16'h0038;
                13: v = 16'h0058;
                15: v = 16'h0048;
                default: v = '0;
            endcase
            default: case (idx)
                'h00: v = 16'h2400;
                'h02: v = 16'h000A;
                'h06: v = 16'h899C;
                'h10: v = 16'h0010;
                'h38: v = 16'h000A;
                'h3A: v = 16'h007F;
                'h3D: v = 16'h0001;
                'h58: v = 16'h0100;
                'h59: v = 16'h1100;
                'h5D: v = 16'h000E;
                'h78: v = 16'h0100;
                'h79: v = 16'h0032;
                'h88: v = 16'h0001;
                'h98: v = 16'h0019;
                default: v = '0;
            endcase
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pcs_regwin_base.sv
module pcs_regwin_base
    import pcs_regwin_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  bus_req_t              req,
    output logic [DATA_W-1:0]     base_q,
    output logic                  base_hit,
    output logic [NUM_BANKS-1:0]  bank_sel
);

    assign base_hit = (req.waddr == BASE_WADDR);

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (req.wr && base_hit)
            base_q <= req.wdata;
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
            assign bank_sel[g] = (base_q == bank_code(bank_e'(g)));
        end
    endgenerate

    // R8: the selector moves only on a write to its own word
    a_r8_base_hold: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && base_hit) |=> $stable(base_q));

    // R3: at most one bank is ever selected
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_sel));

endmodule

// File: rtl/pcs_regwin_bank.sv
module pcs_regwin_bank
    import pcs_regwin_pkg::*;
#(
    parameter bank_e BANK   = BK_CTL,
    parameter int    N_REGS = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                soft_rst,
    input  logic                wr_en,
    input  logic [WADDR_W-1:0]  waddr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

    logic [DATA_W-1:0] regs [N_REGS];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = (waddr < WADDR_W'(N_REGS));
    assign idx      = waddr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            for (int i = 0; i < N_REGS; i++)
                regs[i] <= reg_default(BANK, i);
        end else if (wr_en && in_range) begin
            regs[idx] <= wdata;
        end
    end

    assign rd_data = in_range ? regs[idx] : '0;

    // R4: an accepted write is visible in the register on the next cycle
    a_r4_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_range && !soft_rst) |=> (regs[$past(idx)] == $past(wdata)));

    // R7: a soft reset reloads the first register of every bank
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (regs[0] == reg_default(BANK, 0)));

endmodule

// File: rtl/pcs_regwin.sv
module pcs_regwin
    import pcs_regwin_pkg::*;
#(
    parameter int CTL_BYTES = CTL_BYTES_D,
    parameter int MII_BYTES = MII_BYTES_D,
    parameter int TSY_BYTES = TSY_BYTES_D,
    parameter int VND_BYTES = VND_BYTES_D
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_wr,
    input  logic [11:0]  bus_waddr,
    input  logic [15:0]  bus_wdata,
    output logic [15:0]  bus_rdata
);

    localparam int NREGS [NUM_BANKS] = '{CTL_BYTES / 2, MII_BYTES / 2,
                                         TSY_BYTES / 2, VND_BYTES / 2};

    bus_req_t                req;
    logic [DATA_W-1:0]       base_q;
    logic                    base_hit;
    logic [NUM_BANKS-1:0]    bank_sel;
    logic [DATA_W-1:0]       bank_rd [NUM_BANKS];
    logic                    soft_rst;
    logic [DATA_W-1:0]       rd_mux;

    assign req = '{wr: bus_wr, waddr: bus_waddr, wdata: bus_wdata};

    pcs_regwin_base u_base (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .base_q   (base_q),
        .base_hit (base_hit),
        .bank_sel (bank_sel)
    );

    assign soft_rst = req.wr && !base_hit && bank_sel[BK_MII] &&
                      (req.waddr == '0) && req.wdata[SRST_BIT];

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            pcs_regwin_bank #(
                .BANK   (bank_e'(g)),
                .N_REGS (NREGS[g])
            ) u_bank (
                .clk      (clk),
                .rst      (rst),
                .soft_rst (soft_rst),
                .wr_en    (req.wr && !base_hit && bank_sel[g]),
                .waddr    (req.waddr),
                .wdata    (req.wdata),
                .rd_data  (bank_rd[g])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_sel[b]) rd_mux = rd_mux | bank_rd[b];
    end

    assign bus_rdata = base_hit ? base_q : rd_mux;

    // R5: with no bank selected, everything outside the selector word reads 0
    a_r5_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (!base_hit && (bank_sel == '0)) |-> (bus_rdata == '0));

    // R2: the selector word always returns the selector
    a_r2_base_read: assert property (@(posedge clk) disable iff (rst)
        base_hit |-> (bus_rdata == base_q));

    // R7: bit 15 of the MII control register reads clear after a soft reset
    a_r7_bit_clear: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !g_bank[BK_MII].u_bank.regs[0][SRST_BIT]);

endmodule

// File: tb/sim_pcs_regwin.sv
`timescale 1ns/1ps
module sim_pcs_regwin;
    import pcs_regwin_pkg::*;

    logic        clk = 0;
    logic        rst;
    logic        bus_wr;
    logic [11:0] bus_waddr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    pcs_regwin u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    localparam int SZ [4] = '{9, 16, 17, 227};
    localparam logic [15:0] CODES [4] = '{16'h1E00, 16'h1F00, 16'h1F07, 16'h1F80};

    logic [15:0] m [4][256];
    logic [15:0] m_base;

    function automatic logic [15:0] exp_default(int b, int i);
        logic [15:0] v = 16'h0;
        if (b == 0) begin
            if (i == 4) v = 16'h699E;
            if (i == 8) v = 16'h8000;
        end else if (b == 1) begin
            case (i)
                0: v = 16'h1140; 1: v = 16'h0109; 2: v = 16'h699E;
                3: v = 16'hCED0; 4: v = 16'h0020; 15: v = 16'hC000;
                default: v = 0;
            endcase
        end else if (b == 2) begin
            case (i)
                8: v = 16'h0003; 9: v = 16'h0038; 11: v = 16'h0038;
                13: v = 16'h0058; 15: v = 16'h0048;
                default: v = 0;
            endcase
        end else begin
            case (i)
                'h00: v = 16'h2400; 'h02: v = 16'h000A; 'h06: v = 16'h899C;
                'h10: v = 16'h0010; 'h38: v = 16'h000A; 'h3A: v = 16'h007F;
                'h3D: v = 16'h0001; 'h58: v = 16'h0100; 'h59: v = 16'h1100;
                'h5D: v = 16'h000E; 'h78: v = 16'h0100; 'h79: v = 16'h0032;
                'h88: v = 16'h0001; 'h98: v = 16'h0019;
                default: v = 0;
            endcase
        end
        return v;
    endfunction

    function automatic int bank_of(logic [15:0] base);
        for (int b = 0; b < 4; b++) if (base == CODES[b]) return b;
        return -1;
    endfunction

    function automatic logic [15:0] exp_read(logic [11:0] a);
        int b;
        if (a == 12'h0FF) return m_base;
        b = bank_of(m_base);
        if (b < 0) return 16'h0;
        if (a >= 12'(SZ[b])) return 16'h0;
        return m[b][a];
    endfunction

    task automatic model_defaults();
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 256; i++) m[b][i] = exp_default(b, i);
    endtask

    task automatic model_write(logic [11:0] a, logic [15:0] d);
        int b;
        if (a == 12'h0FF) begin m_base = d; return; end
        b = bank_of(m_base);
        if (b < 0 || a >= 12'(SZ[b])) return;
        if (b == 1 && a == 0 && d[15]) model_defaults();
        else m[b][a] = d;
    endtask

    task automatic wr(logic [11:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1; bus_waddr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 0;
        model_write(a, d);
    endtask

    task automatic rd_chk(logic [11:0] a, string req);
        logic [15:0] e;
        @(negedge clk);
        bus_wr = 0; bus_waddr = a;
        #1;
        e = exp_read(a);
        n_vec++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s addr=%03h base=%04h got=%04h exp=%04h",
                     req, a, m_base, bus_rdata, e);
        end
    endtask

    task automatic scan_all(string req);
        for (int b = 0; b < 4; b++) begin
            wr(12'h0FF, CODES[b]);
            for (int i = 0; i < SZ[b] + 2; i++) rd_chk(12'(i), req);
        end
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        bus_wr = 0; bus_waddr = 0; bus_wdata = 0; rst = 1;
        model_defaults(); m_base = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state, base 0 and defaults everywhere
        rd_chk(12'h0FF, "R1");
        rd_chk(12'h004, "R5");              // base 0 is unknown
        scan_all("R1");

        // R2, R3: selector word reachable from every bank
        wr(12'h0FF, 16'h1F07); rd_chk(12'h0FF, "R2"); rd_chk(12'h008, "R3");
        // R10: changing address alone changes data in the same cycle
        rd_chk(12'h009, "R10");

        // R4: write in time-sync bank, other banks untouched
        wr(12'h00F, 16'hBEEF); rd_chk(12'h00F, "R4");
        wr(12'h0FF, 16'h1E00); rd_chk(12'h00F, "R4");

        // R6: boundary index == size
        wr(12'h0FF, 16'h1E00); wr(12'h009, 16'h1234); rd_chk(12'h009, "R6");
        rd_chk(12'h008, "R6");
        wr(12'h0FF, 16'h1F80); wr(12'd227, 16'h5555); rd_chk(12'd227, "R6");
        wr(12'd226, 16'hA5A5); rd_chk(12'd226, "R6");

        // R5: near-miss base code
        wr(12'h0FF, 16'h1F01); wr(12'h000, 16'h7777); rd_chk(12'h000, "R5");
        scan_all("R5");

        // R9: MII control write without bit 15
        wr(12'h0FF, 16'h1F00); wr(12'h000, 16'h0140); rd_chk(12'h000, "R9");
        rd_chk(12'h003, "R9");

        // R7, R8: soft reset with dirty banks
        wr(12'h0FF, 16'h1F80); wr(12'h000, 16'h1111);
        wr(12'h0FF, 16'h1F00); wr(12'h001, 16'h2222);
        wr(12'h000, 16'h8000);
        rd_chk(12'h0FF, "R8");
        rd_chk(12'h000, "R7");
        rd_chk(12'h001, "R7");
        scan_all("R7");

        // random mix against the model (R4 R5 R6 R7)
        for (int k = 0; k < 1500; k++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) begin
                logic [15:0] bsel = ($urandom_range(0, 4) == 4) ? 16'($urandom)
                                    : CODES[$urandom_range(0, 3)];
                wr(12'h0FF, bsel);
            end else if (op <= 4) begin
                logic [11:0] a = 12'($urandom_range(0, 240));
                logic [15:0] d = 16'($urandom);
                if ($urandom_range(0, 15) != 0) d[15] = 1'b0;
                wr(a, d);
            end else begin
                rd_chk(12'($urandom_range(0, 260)), "R4");
            end
        end
        scan_all("R4");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule